// File: doc/BRIEF.md
# Two-Level Masked Interrupt Controller

This controller sits between a small processor core and the request sources around it. It collects four external maskable request pins, a bank of peripheral event lines, an active-low non-maskable pin and software interrupt commands from the core. It picks one request at a time, presents the chosen vector address to the core, and holds it until the core acknowledges. Each maskable request must pass its own source enable, then the core mask bit of the line it lands on, and finally the global disable flag. Non-maskable and software requests bypass those gates, each under a fixed rule.

A maskable request is latched into a per-line pending flag. The controller offers it one clock later if nothing else is on offer and all gates are open. A masked request stays pending until the mask opens or reset clears it. On acknowledge, the controller clears the pending state of the taken source and updates the global disable flag and the non-maskable service flag according to the kind of interrupt taken. The core signals the end of a non-maskable handler with a return strobe, and it can load the global disable flag directly.

Top module: `dual_mask_intc`

## Requirements
- R1: While reset is asserted and right after it, irq_valid is 0, intm is 1, nmi_active is 0 and nothing is pending.
- R2: An external request is an active-high level sampled every clock. With ext_en low it is not remembered. With ext_en high it sets the line's pending flag, which is offered only while imr of that line is 1 and intm is 0. The flag persists while it is blocked by imr or intm.
- R3: Peripheral event j counts only while per_en[j] is 1, and it lands on core line N_EXT + (j mod (N_LINES - N_EXT)). With the defaults, even events go to line 4 and odd events to line 5.
- R4: Among the eligible maskable lines the lowest-numbered line wins, its vector is 2*(k+1), and acknowledging it sets intm to 1.
- R5: irq_valid and irq_vec stay unchanged until irq_ack is seen with irq_valid high. An irq_ack while irq_valid is low has no effect. An acknowledge drops irq_valid and clears the taken line's pending flag.
- R6: nmi_n passes two synchronizing flops. Each falling edge creates exactly one pending non-maskable request with vector 0x24, whatever imr and intm hold. A pin held low produces no further request.
- R7: Priority order for a new offer: non-maskable first, then a software vectored or trap command, then maskable lines.
- R8: Acknowledging a non-maskable interrupt sets nmi_active and intm. While nmi_active is 1, a new non-maskable request stays pending and is not offered. nmi_ret clears nmi_active.
- R9: sw_cmd encoding is 0 none, 1 vectored, 2 non-maskable, 3 trap. A vectored command offers vector sw_vec, and its acknowledge sets intm. Vectored and trap commands share one slot, and a command of either kind that arrives while the slot is held (until acknowledge) is dropped.
- R10: A software non-maskable command joins the pin's path: vector 0x24, the same lockout, and intm set on acknowledge.
- R11: A trap command offers vector 0x22, and its acknowledge leaves intm unchanged, so maskable lines can still be taken in its handler.
- R12: intm_wr loads intm_val into intm. If an acknowledge of a non-trap interrupt happens in the same cycle, intm becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_req | input | N_EXT | External maskable request levels, active high |
| ext_en | input | N_EXT | Per-pin source enable |
| per_req | input | N_PER | Peripheral event request levels |
| per_en | input | N_PER | Per-event source enable |
| imr | input | N_LINES | Core mask, 1 lets a line through |
| nmi_n | input | 1 | Non-maskable request pin, asynchronous, falling edge |
| sw_cmd | input | 2 | Software command, one-cycle strobe (0 none, 1 vectored, 2 NMI, 3 trap) |
| sw_vec | input | VEC_W | Operand of a vectored software command |
| intm_wr | input | 1 | Load strobe for the global disable flag |
| intm_val | input | 1 | Value written by intm_wr |
| nmi_ret | input | 1 | End of non-maskable handler |
| irq_ack | input | 1 | Core acknowledge of the offered vector |
| irq_valid | output | 1 | A vector is on offer |
| irq_vec | output | VEC_W | Offered vector address |
| intm | output | 1 | Global maskable-interrupt disable flag |
| nmi_active | output | 1 | Non-maskable handler in progress |

## Verification
The main arbitration is tried with single requests, with several lines made pending in the same cycle while intm blocks them, and with requests arriving while a source enable or an imr bit is closed. These patterns separate the priority order from latching and show that an enable-gated request leaves no trace. Mixed patterns put a non-maskable edge, a software command and a maskable line into competition in the same cycle or within two cycles, which tells priority between classes apart from arrival order. Lockout patterns repeat a non-maskable edge during service and keep the pin low, which separates edge from level detection. Slot collision, an acknowledge while idle, and intm writes coinciding with an acknowledge cover the remaining corners.

// File: rtl/intc_pkg.sv
package intc_pkg;

  typedef enum logic [1:0] {
    SW_NONE = 2'd0,
    SW_VEC  = 2'd1,
    SW_NMI  = 2'd2,
    SW_TRAP = 2'd3
  } sw_cmd_e;

  typedef enum logic [1:0] {
    K_MASK = 2'd0,
    K_NMI  = 2'd1,
    K_VEC  = 2'd2,
    K_TRAP = 2'd3
  } take_kind_e;

  localparam int unsigned NMI_VECTOR  = 32'h24;
  localparam int unsigned TRAP_VECTOR = 32'h22;

  // vector address of maskable core line k
  function automatic int unsigned line_vector(int unsigned k);
    return 2 * (k + 1);
  endfunction

  // core line that peripheral event j is folded onto
  function automatic int unsigned periph_line(int unsigned j, int unsigned n_ext,
                                              int unsigned n_lines);
    return n_ext + (j % (n_lines - n_ext));
  endfunction

endpackage

// File: rtl/intc_nmi_edge.sv
module intc_nmi_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_n,
  output logic nmi_fall
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], nmi_n};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign nmi_fall = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/intc_line_gate.sv
module intc_line_gate import intc_pkg::*; #(
  parameter int unsigned N_EXT   = 4,
  parameter int unsigned N_PER   = 8,
  parameter int unsigned N_LINES = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_EXT-1:0]   ext_req,
  input  logic [N_EXT-1:0]   ext_en,
  input  logic [N_PER-1:0]   per_req,
  input  logic [N_PER-1:0]   per_en,
  input  logic [N_LINES-1:0] clr_line,
  output logic [N_LINES-1:0] pend
);
  // which peripheral events fold onto line k
  function automatic logic [N_PER-1:0] lane_mask(int unsigned k);
    logic [N_PER-1:0] m;
    m = '0;
    for (int unsigned j = 0; j < N_PER; j++)
      m[j] = (periph_line(j, N_EXT, N_LINES) == k);
    return m;
  endfunction

  logic [N_PER-1:0]   per_hit;
  logic [N_LINES-1:0] raw;

  assign per_hit = per_req & per_en;

  for (genvar k = 0; k < N_LINES; k++) begin : g_line
    localparam logic [N_PER-1:0] PMASK = lane_mask(k);
    if (k < N_EXT) begin : g_ext
      assign raw[k] = (ext_req[k] & ext_en[k]) | (|(per_hit & PMASK));
    end else begin : g_per
      assign raw[k] = |(per_hit & PMASK);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_line) | raw;
  end
endmodule

// File: rtl/intc_pick.sv
module intc_pick #(
  parameter int unsigned N  = 6,
  parameter int unsigned IW = 3
) (
  input  logic [N-1:0]  elig,
  output logic          found,
  output logic [IW-1:0] idx
);
  // lowest index wins: scan downward so the last hit is the lowest
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/dual_mask_intc.sv
module dual_mask_intc import intc_pkg::*; #(
  parameter int unsigned N_EXT    = 4,
  parameter int unsigned N_PER    = 8,
  parameter int unsigned N_LINES  = 6,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned NMI_SYNC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_EXT-1:0]   ext_req,
  input  logic [N_EXT-1:0]   ext_en,
  input  logic [N_PER-1:0]   per_req,
  input  logic [N_PER-1:0]   per_en,
  input  logic [N_LINES-1:0] imr,
  input  logic               nmi_n,
  input  logic [1:0]         sw_cmd,
  input  logic [VEC_W-1:0]   sw_vec,
  input  logic               intm_wr,
  input  logic               intm_val,
  input  logic               nmi_ret,
  input  logic               irq_ack,
  output logic               irq_valid,
  output logic [VEC_W-1:0]   irq_vec,
  output logic               intm,
  output logic               nmi_active
);
  localparam int unsigned LINE_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;

  sw_cmd_e cmd;
  assign cmd = sw_cmd_e'(sw_cmd);

  // non-maskable edge
  logic nmi_fall;
  intc_nmi_edge #(.STAGES(NMI_SYNC)) u_nmi (
    .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .nmi_fall(nmi_fall)
  );

  // maskable pending flags and first-level gating
  logic [N_LINES-1:0] pend, clr_line, elig;
  intc_line_gate #(.N_EXT(N_EXT), .N_PER(N_PER), .N_LINES(N_LINES)) u_gate (
    .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .ext_en(ext_en),
    .per_req(per_req), .per_en(per_en), .clr_line(clr_line), .pend(pend)
  );

  // second-level gating by the core mask
  assign elig = pend & imr;

  logic              mask_found;
  logic [LINE_W-1:0] mask_idx;
  intc_pick #(.N(N_LINES), .IW(LINE_W)) u_pick (
    .elig(elig), .found(mask_found), .idx(mask_idx)
  );

  // state
  logic              nmi_pend, nmi_act_q, intm_q;
  logic              sw_full;
  take_kind_e        sw_kind;
  logic [VEC_W-1:0]  sw_vec_q;
  logic              valid_q;
  logic [VEC_W-1:0]  vec_q;
  take_kind_e        offer_kind;
  logic [LINE_W-1:0] offer_line;

  // named internal events
  logic ack_take, nmi_ready, start_offer, sw_accept;
  logic              cand_found;
  take_kind_e        cand_kind;
  logic [VEC_W-1:0]  cand_vec;
  logic [LINE_W-1:0] cand_line;

  assign ack_take  = valid_q & irq_ack;
  assign nmi_ready = nmi_pend & ~nmi_act_q;
  assign sw_accept = ~sw_full & ((cmd == SW_VEC) | (cmd == SW_TRAP));

  // class priority: non-maskable, software slot, maskable (third gate: intm)
  always_comb begin
    cand_found = 1'b0;
    cand_kind  = K_MASK;
    cand_vec   = '0;
    cand_line  = '0;
    if (nmi_ready) begin
      cand_found = 1'b1;
      cand_kind  = K_NMI;
      cand_vec   = VEC_W'(NMI_VECTOR);
    end else if (sw_full) begin
      cand_found = 1'b1;
      cand_kind  = sw_kind;
      cand_vec   = sw_vec_q;
    end else if (!intm_q && mask_found) begin
      cand_found = 1'b1;
      cand_kind  = K_MASK;
      cand_vec   = VEC_W'(line_vector(32'(mask_idx)));
      cand_line  = mask_idx;
    end
  end

  assign start_offer = ~valid_q & cand_found;
  assign clr_line    = (ack_take && offer_kind == K_MASK)
                       ? (N_LINES'(1) << offer_line) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_pend   <= 1'b0;
      nmi_act_q  <= 1'b0;
      intm_q     <= 1'b1;
      sw_full    <= 1'b0;
      sw_kind    <= K_VEC;
      sw_vec_q   <= '0;
      valid_q    <= 1'b0;
      vec_q      <= '0;
      offer_kind <= K_MASK;
      offer_line <= '0;
    end else begin
      if (nmi_fall || cmd == SW_NMI)            nmi_pend <= 1'b1;
      else if (ack_take && offer_kind == K_NMI) nmi_pend <= 1'b0;

      if (ack_take && offer_kind == K_NMI) nmi_act_q <= 1'b1;
      else if (nmi_ret)                    nmi_act_q <= 1'b0;

      if (ack_take && offer_kind != K_TRAP) intm_q <= 1'b1;
      else if (intm_wr)                     intm_q <= intm_val;

      if (sw_accept) begin
        sw_full  <= 1'b1;
        sw_kind  <= (cmd == SW_VEC) ? K_VEC : K_TRAP;
        sw_vec_q <= (cmd == SW_VEC) ? sw_vec : VEC_W'(TRAP_VECTOR);
      end else if (ack_take && (offer_kind == K_VEC || offer_kind == K_TRAP)) begin
        sw_full <= 1'b0;
      end

      if (start_offer) begin
        valid_q    <= 1'b1;
        vec_q      <= cand_vec;
        offer_kind <= cand_kind;
        offer_line <= cand_line;
      end else if (ack_take) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign irq_valid  = valid_q;
  assign irq_vec    = vec_q;
  assign intm       = intm_q;
  assign nmi_active = nmi_act_q;
endmodule

// File: rtl/dual_mask_intc_chk.sv
module dual_mask_intc_chk import intc_pkg::*; #(
  parameter int unsigned N_LINES = 6,
  parameter int unsigned VEC_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq_valid,
  input logic               irq_ack,
  input logic [VEC_W-1:0]   irq_vec,
  input logic               intm,
  input logic               intm_wr,
  input logic               intm_val,
  input logic               nmi_active,
  input logic               start_offer,
  input logic               nmi_ready,
  input take_kind_e         cand_kind,
  input take_kind_e         offer_kind,
  input logic [N_LINES-1:0] clr_line
);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && !irq_ack |=> irq_valid && $stable(irq_vec));

  p_ack_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && irq_ack |=> !irq_valid);

  p_clr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_line));

  p_mask_needs_intm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_offer && cand_kind == K_MASK |-> !intm);

  p_take_sets_intm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && irq_ack && offer_kind != K_TRAP |=> intm);

  p_nmi_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && offer_kind == K_NMI |-> irq_vec == VEC_W'(NMI_VECTOR));

  p_nmi_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_offer && nmi_ready |-> cand_kind == K_NMI);

  p_nmi_lockout_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_offer && cand_kind == K_NMI |-> !nmi_active);

  p_nmi_enter_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && irq_ack && offer_kind == K_NMI |=> nmi_active && intm);

  p_trap_vector_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && offer_kind == K_TRAP |-> irq_vec == VEC_W'(TRAP_VECTOR));

  p_trap_keeps_intm_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && irq_ack && offer_kind == K_TRAP && !intm_wr |=> intm == $past(intm));

  p_intm_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    intm_wr && !(irq_valid && irq_ack) |=> intm == $past(intm_val));
endmodule

bind dual_mask_intc dual_mask_intc_chk #(.N_LINES(N_LINES), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_ack(irq_ack),
  .irq_vec(irq_vec), .intm(intm), .intm_wr(intm_wr), .intm_val(intm_val),
  .nmi_active(nmi_active), .start_offer(start_offer), .nmi_ready(nmi_ready),
  .cand_kind(cand_kind), .offer_kind(offer_kind), .clr_line(clr_line)
);

// File: tb/dual_mask_intc_bench.sv
`timescale 1ns/1ps
module dual_mask_intc_bench;
  localparam int NE = 4, NP = 8, NL = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NE-1:0] ext_req = '0, ext_en = '1;
  logic [NP-1:0] per_req = '0, per_en = '1;
  logic [NL-1:0] imr = '1;
  logic nmi_n = 1'b1;
  logic [1:0] sw_cmd = 2'd0;
  logic [7:0] sw_vec = '0;
  logic intm_wr = 0, intm_val = 0, nmi_ret = 0, irq_ack = 0;
  logic irq_valid, intm, nmi_active;
  logic [7:0] irq_vec;

  dual_mask_intc u_dual_mask_intc (
    .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .ext_en(ext_en),
    .per_req(per_req), .per_en(per_en), .imr(imr), .nmi_n(nmi_n),
    .sw_cmd(sw_cmd), .sw_vec(sw_vec), .intm_wr(intm_wr), .intm_val(intm_val),
    .nmi_ret(nmi_ret), .irq_ack(irq_ack), .irq_valid(irq_valid),
    .irq_vec(irq_vec), .intm(intm), .nmi_active(nmi_active)
  );

  always #4 clk = ~clk;  // 125 MHz

  int tests = 0, fails = 0;
  bit done = 0;
  string phase = "R1";

  // behavioural reference: kinds 0 maskable, 1 nmi, 2 vectored, 3 trap
  bit m_s1, m_s2, m_prev, m_npend, m_act, m_intm, m_full, m_valid;
  bit [NL-1:0] m_pend;
  int m_skind, m_svec, m_vec, m_kind, m_line;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_s1, m_s2, m_prev} = 3'b111;
      m_npend = 0; m_act = 0; m_intm = 1; m_full = 0; m_valid = 0;
      m_pend = '0; m_skind = 2; m_svec = 0; m_vec = 0; m_kind = 0; m_line = 0;
    end else begin
      bit fall, take, found;
      int ck, cv, cl;
      bit [NL-1:0] np;
      fall = m_prev && !m_s2;
      take = m_valid && irq_ack;
      found = 0; ck = 0; cv = 0; cl = 0;
      if (m_npend && !m_act) begin found = 1; ck = 1; cv = 'h24; end
      else if (m_full) begin found = 1; ck = m_skind; cv = m_svec; end
      else if (!m_intm) begin
        for (int k = NL - 1; k >= 0; k--)
          if (m_pend[k] && imr[k]) begin found = 1; ck = 0; cv = 2 * (k + 1); cl = k; end
      end
      np = m_pend;
      if (take && m_kind == 0) np[m_line] = 0;
      for (int k = 0; k < NE; k++) if (ext_req[k] && ext_en[k]) np[k] = 1;
      for (int j = 0; j < NP; j++) if (per_req[j] && per_en[j]) np[NE + j % (NL - NE)] = 1;
      m_pend = np;
      if (fall || sw_cmd == 2) m_npend = 1; else if (take && m_kind == 1) m_npend = 0;
      if (!m_full && (sw_cmd == 1 || sw_cmd == 3)) begin
        m_full = 1; m_skind = (sw_cmd == 1) ? 2 : 3; m_svec = (sw_cmd == 1) ? int'(sw_vec) : 'h22;
      end else if (take && (m_kind == 2 || m_kind == 3)) m_full = 0;
      if (take && m_kind == 1) m_act = 1; else if (nmi_ret) m_act = 0;
      if (take && m_kind != 3) m_intm = 1; else if (intm_wr) m_intm = intm_val;
      if (!m_valid && found) begin m_valid = 1; m_vec = cv; m_kind = ck; m_line = cl; end
      else if (take) m_valid = 0;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = nmi_n;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      tests++;
      if (irq_valid !== m_valid || (m_valid && irq_vec !== m_vec[7:0]) ||
          intm !== m_intm || nmi_active !== m_act) begin
        fails++;
        $display("FAIL %s model: valid/vec/intm/act actual %0b/%0h/%0b/%0b expected %0b/%0h/%0b/%0b",
                 phase, irq_valid, irq_vec, intm, nmi_active, m_valid, m_vec, m_intm, m_act);
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_offer(string tag, int exp);
    int n = 0;
    while (!irq_valid && n < 20) begin @(negedge clk); n++; end
    check(tag, irq_valid ? int'(irq_vec) : 'hFFFF, exp);
  endtask

  task automatic quiet(string tag, int n);
    repeat (n) @(negedge clk);
    check(tag, int'(irq_valid), 0);
  endtask

  task automatic ack();
    irq_ack = 1; @(negedge clk); irq_ack = 0;
  endtask

  task automatic set_intm(bit v);
    intm_wr = 1; intm_val = v; @(negedge clk); intm_wr = 0;
  endtask

  task automatic sw(int c, int v);
    sw_cmd = 2'(c); sw_vec = 8'(v); @(negedge clk); sw_cmd = 0;
  endtask

  task automatic ext_pulse(int k);
    ext_req[k] = 1; @(negedge clk); ext_req[k] = 0;
  endtask

  task automatic pulse_ret();
    nmi_ret = 1; @(negedge clk); nmi_ret = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(irq_valid), 0);
    check("R1 intm in reset", int'(intm), 1);
    rst_n = 1; @(negedge clk);
    check("R1 nmi_active", int'(nmi_active), 0);
    // R1/R2: request while intm=1 stays pending
    phase = "R2";
    ext_pulse(2);
    quiet("R1 intm blocks", 3);
    set_intm(0);
    check("R12 intm write", int'(intm), 0);
    wait_offer("R2 pending kept", 6);
    ack();
    check("R4 ack sets intm", int'(intm), 1);
    // source enable and imr
    set_intm(0);
    ext_en[1] = 0; ext_pulse(1);
    quiet("R2 source enable", 4);
    ext_en[1] = 1;
    imr[3] = 0; ext_pulse(3);
    quiet("R2 imr blocks", 4);
    imr[3] = 1;
    wait_offer("R2 imr opens", 8);
    ack();
    set_intm(0);
    quiet("R2 disabled request forgotten", 4);
    // priority among lines
    phase = "R4";
    set_intm(1);
    ext_req[3] = 1; ext_req[1] = 1; per_req[1] = 1;
    @(negedge clk); ext_req = '0; per_req = '0;
    set_intm(0);
    wait_offer("R4 lowest line", 4);
    ack();
    set_intm(0);
    wait_offer("R4 next line", 8);
    ack();
    set_intm(0);
    wait_offer("R3 odd event line 5", 12);
    ack();
    // peripheral enable
    phase = "R3";
    set_intm(0);
    per_en[2] = 0; per_req[2] = 1; @(negedge clk); per_req[2] = 0;
    quiet("R3 per_en blocks", 4);
    per_en[2] = 1; per_req[2] = 1; @(negedge clk); per_req[2] = 0;
    wait_offer("R3 even event line 4", 10);
    ack();
    // handshake
    phase = "R5";
    set_intm(0);
    ack();
    check("R5 idle ack ignored", int'(intm), 0);
    ext_pulse(0);
    wait_offer("R5 offer", 2);
    repeat (5) @(negedge clk);
    check("R5 held valid", int'(irq_valid), 1);
    check("R5 held vec", int'(irq_vec), 2);
    ack();
    check("R5 ack drops valid", int'(irq_valid), 0);
    // NMI pin ignores imr/intm, one request per edge
    phase = "R6";
    imr = '0;
    nmi_n = 0;
    wait_offer("R6 nmi vector", 'h24);
    ack();
    check("R8 nmi_active set", int'(nmi_active), 1);
    check("R8 intm set", int'(intm), 1);
    pulse_ret();
    check("R8 nmi_ret clears", int'(nmi_active), 0);
    quiet("R6 held low single", 6);
    nmi_n = 1; repeat (3) @(negedge clk);
    // lockout
    phase = "R8";
    nmi_n = 0;
    wait_offer("R8 first nmi", 'h24);
    ack();
    nmi_n = 1; repeat (3) @(negedge clk);
    nmi_n = 0;
    quiet("R8 locked out", 6);
    pulse_ret();
    wait_offer("R8 released", 'h24);
    ack(); pulse_ret();
    nmi_n = 1; repeat (3) @(negedge clk);
    imr = '1;
    // class priority
    phase = "R7";
    set_intm(0);
    sw_cmd = 2; ext_req[0] = 1; @(negedge clk); sw_cmd = 0; ext_req[0] = 0;
    wait_offer("R7 nmi over mask", 'h24);
    ack(); pulse_ret();
    set_intm(0);
    wait_offer("R7 mask after nmi", 2);
    ack();
    set_intm(0);
    sw_cmd = 1; sw_vec = 8'h40; ext_req[0] = 1; @(negedge clk); sw_cmd = 0; ext_req[0] = 0;
    wait_offer("R7 sw over mask", 'h40);
    ack(); set_intm(0);
    wait_offer("R7 mask after sw", 2);
    ack();
    nmi_n = 0; repeat (2) @(negedge clk);
    sw(1, 'h41);
    wait_offer("R7 nmi over sw", 'h24);
    ack();
    wait_offer("R7 sw after nmi", 'h41);
    ack(); pulse_ret();
    nmi_n = 1; repeat (3) @(negedge clk);
    // vectored command and slot collision
    phase = "R9";
    set_intm(0);
    sw(1, 'h5A);
    wait_offer("R9 operand vector", 'h5A);
    sw(3, 0);
    ack();
    check("R9 sets intm", int'(intm), 1);
    quiet("R9 busy slot drops", 4);
    // trap
    phase = "R11";
    set_intm(0);
    sw(3, 0);
    wait_offer("R11 trap vector", 'h22);
    ack();
    check("R11 intm kept", int'(intm), 0);
    ext_pulse(2);
    wait_offer("R11 mask in trap", 6);
    ack();
    // software nmi
    phase = "R10";
    imr = '0;
    sw(2, 0);
    wait_offer("R10 sw nmi vector", 'h24);
    ack();
    check("R10 sw nmi active", int'(nmi_active), 1);
    pulse_ret();
    imr = '1;
    // intm write vs ack
    phase = "R12";
    set_intm(1);
    check("R12 write one", int'(intm), 1);
    set_intm(0);
    ext_pulse(1);
    wait_offer("R12 offer", 4);
    intm_wr = 1; intm_val = 0; ack(); intm_wr = 0;
    check("R12 ack wins", int'(intm), 1);
    // reset mid-offer
    phase = "R1";
    set_intm(0);
    ext_pulse(0);
    wait_offer("R1 pre-reset offer", 2);
    rst_n = 0; @(negedge clk);
    check("R1 reset drops valid", int'(irq_valid), 0);
    check("R1 reset intm", int'(intm), 1);
    rst_n = 1;
    set_intm(0);
    quiet("R1 pending cleared", 4);
    finish_run();
  end
endmodule